// File: doc/BRIEF.md
# Spike-Interval Top-K Channel Selector

This block watches a group of spiking channels and reports, as a bit mask, which of them fire fastest. A one-cycle read-start pulse opens a measurement. From that moment each channel holds an interval pulse high until it has produced two spikes, so a channel that fires often ends its pulse early and a slow channel ends it late. The mask marks the channels whose intervals end among the earliest K_SEL, and a done flag reports that the result is final.

The selection uses no comparators or per-channel rankings. Every group of N_CH−K_SEL+1 interval pulses is ANDed. The AND of such a group falls as soon as its earliest member falls, and any group that size must contain one of the K_SEL earliest channels. So a channel is selected exactly when its own pulse falls in the same clock cycle as one of the group ANDs. A programmable timeout closes a measurement in which some channels never spike twice, and such channels are never selected. The mask and the done flag then hold until the next read start.

Top module: `spike_topk_detector`

## Requirements
- R1: After reset, `topk_mask` is all zeros and `done` is low.
- R2: A `read_start` pulse clears `topk_mask` and `done` in the next cycle and opens a new measurement.
- R3: Each spike input passes through a two-flop synchronizer. Each 0-to-1 transition after the read start counts as one spike, and a channel's interval ends at its second counted spike. A channel with a single spike never ends its interval by spiking.
- R4: Once every interval has ended, bit i of `topk_mask` belongs to channel i. The bit is 1 exactly when fewer than K_SEL (3) channels ended in a strictly earlier cycle. When all ending cycles are distinct, this marks the three earliest channels.
- R5: Channels whose intervals end in the same cycle at the K_SEL-th rank are all marked, so more than three mask bits may be set.
- R6: `done` stays low while any interval is still open and the timeout has not been reached. It rises after the last interval ends, and whenever it is high no interval is open.
- R7: If `tmo_limit` cycles pass after the read start, the measurement closes and `done` rises. Channels that have not seen two spikes by then are never marked. Channels that finished before the timeout are marked by the R4 rule, with each unfinished channel counted as ending last.
- R8: While `done` is high and no new read start arrives, `topk_mask` and `done` hold, and further spikes have no effect on them.
- R9: A read start during an open measurement discards its spike counts. Spikes seen before the restart do not count toward any channel's two spikes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| read_start | input | 1 | One-cycle pulse that opens a measurement |
| spike_in | input | N_CH | Raw spike inputs, one per channel, asynchronous |
| tmo_limit | input | TMO_W | Timeout in cycles counted from the read start |
| topk_mask | output | N_CH | Selected channels, bit i = channel i |
| done | output | 1 | Result is final; held until the next read start |

## Verification
The assertions assume that each spike stays high for at least two clock cycles and low for at least two cycles between spikes, so that the synchronizer sees every transition exactly once. They also assume that `read_start` is held steady around clock edges and that `tmo_limit` does not change during a measurement. The stimulus drives spikes as two-cycle pulses with gaps of two or more cycles, and it changes every input only at the falling clock edge. Spike times are placed well inside the timeout window, except in the cases that are meant to reach the timeout.

// File: rtl/tkd_pkg.sv
`timescale 1ns/1ps
package tkd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_HOLD = 2'd2
  } tkd_state_e;

  // number of set bits in a word
  function automatic int ones(input logic [31:0] v);
    int c;
    c = 0;
    for (int b = 0; b < 32; b++) c += int'(v[b]);
    return c;
  endfunction

  // size of the channel groups whose AND tracks the earliest members
  function automatic int group_size(input int n, input int k);
    return n - k + 1;
  endfunction

endpackage

// File: rtl/tkd_spike_edge.sv
`timescale 1ns/1ps
module tkd_spike_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic spk_raw,
  output logic spk_rise
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], spk_raw};
  end

  // sh[0], sh[1] form the synchronizer; sh[2] delays for edge detection
  assign spk_rise = sh[1] & ~sh[2];
endmodule

// File: rtl/tkd_interval.sv
`timescale 1ns/1ps
module tkd_interval #(
  parameter int END_CNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  input  logic spk_rise,
  output logic q
);
  localparam int CW = $clog2(END_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(END_CNT - 1);

  logic [CW-1:0] cnt;
  logic          q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      q_r <= 1'b1;
      cnt <= '0;
    end else if (clr) begin
      q_r <= 1'b0;
    end else if (q_r && spk_rise) begin
      if (cnt == LAST) q_r <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign q = q_r;

  // R3: an interval only ends on a detected spike or on the timeout clear
  p_end_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_r) |-> ($past(spk_rise) || $past(clr)));

  // R8: an ended interval stays ended until the next start
  p_stay_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_r && !start) |=> !q_r);
endmodule

// File: rtl/tkd_match.sv
`timescale 1ns/1ps
module tkd_match
  import tkd_pkg::*;
#(
  parameter int N_CH  = 6,
  parameter int K_SEL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            enable,
  input  logic [N_CH-1:0] q,
  output logic [N_CH-1:0] fp
);
  localparam int SUB_SZ = group_size(N_CH, K_SEL);
  localparam int N_MSK  = 1 << N_CH;

  logic [N_CH-1:0]  q_d;
  logic [N_CH-1:0]  fall;
  logic [N_MSK-1:0] grp_fall;
  logic             any_grp_fall;
  logic [N_CH-1:0]  fp_r;

  always_ff @(posedge clk) begin
    if (!rst_n) q_d <= '0;
    else        q_d <= q;
  end

  assign fall = q_d & ~q;

  // one AND term per channel group of SUB_SZ members; other masks unused
  for (genvar m = 0; m < N_MSK; m++) begin : g_grp
    localparam logic [N_CH-1:0] MSK = N_CH'(m);
    if (ones(32'(m)) == SUB_SZ) begin : g_on
      logic and_prev, and_now;
      assign and_prev    = ((q_d & MSK) == MSK);
      assign and_now     = ((q   & MSK) == MSK);
      assign grp_fall[m] = and_prev & ~and_now;
    end else begin : g_off
      assign grp_fall[m] = 1'b0;
    end
  end

  assign any_grp_fall = |grp_fall;

  always_ff @(posedge clk) begin
    if (!rst_n)                         fp_r <= '0;
    else if (start)                     fp_r <= '0;
    else if (enable && any_grp_fall)    fp_r <= fp_r | fall;
  end

  assign fp = fp_r;

  // R2: a start empties the mask
  p_fp_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (fp_r == '0));

  // R8: outside a measurement the mask holds
  p_fp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !start) |=> $stable(fp_r));

  // R4: a newly set bit belongs to a channel whose interval just ended
  p_new_bit_fell_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !start) |=> (((fp_r & ~$past(fp_r)) & ~$past(fall)) == '0));
endmodule

// File: rtl/tkd_ctrl.sv
`timescale 1ns/1ps
module tkd_ctrl
  import tkd_pkg::*;
#(
  parameter int N_CH  = 6,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_CH-1:0]  q,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy,
  output logic             tmo_hit,
  output logic             all_ended,
  output logic             done_o
);
  tkd_state_e       st;
  logic [TMO_W-1:0] timer;

  assign busy      = (st == ST_MEAS);
  assign all_ended = busy && (q == '0);
  assign tmo_hit   = busy && (timer == tmo_limit);
  assign done_o    = (st == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      timer <= '0;
    end else if (start) begin
      st    <= ST_MEAS;
      timer <= '0;
    end else if (busy) begin
      if (all_ended || tmo_hit) st <= ST_HOLD;
      else                      timer <= timer + 1'b1;
    end
  end

  // R2: start always clears done
  p_start_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_o);

  // R7: reaching the limit closes the measurement
  p_tmo_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !start) |=> done_o);

  // R8: done holds until a start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start) |=> done_o);
endmodule

// File: rtl/spike_topk_detector.sv
`timescale 1ns/1ps
module spike_topk_detector
  import tkd_pkg::*;
#(
  parameter int N_CH    = 6,
  parameter int K_SEL   = 3,
  parameter int TMO_W   = 16,
  parameter int END_CNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             read_start,
  input  logic [N_CH-1:0]  spike_in,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [N_CH-1:0]  topk_mask,
  output logic             done
);
  logic [N_CH-1:0] spk_rise;
  logic [N_CH-1:0] q_vec;
  logic            busy, tmo_hit, all_ended;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tkd_spike_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .spk_raw  (spike_in[i]),
      .spk_rise (spk_rise[i])
    );
    tkd_interval #(.END_CNT(END_CNT)) u_ivl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (read_start),
      .clr      (tmo_hit),
      .spk_rise (spk_rise[i]),
      .q        (q_vec[i])
    );
  end

  tkd_ctrl #(.N_CH(N_CH), .TMO_W(TMO_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (read_start),
    .q         (q_vec),
    .tmo_limit (tmo_limit),
    .busy      (busy),
    .tmo_hit   (tmo_hit),
    .all_ended (all_ended),
    .done_o    (done)
  );

  tkd_match #(.N_CH(N_CH), .K_SEL(K_SEL)) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (read_start),
    .enable (busy),
    .q      (q_vec),
    .fp     (topk_mask)
  );

  // R6: a final result never coexists with an open interval
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (q_vec == '0));

  // R4: a measurement where every channel finished marks at least K_SEL channels
  p_topk_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (all_ended && !read_start) |=> ($countones(topk_mask) >= K_SEL));
endmodule

// File: tb/spike_topk_detector_test.sv
`timescale 1ns/1ps
module spike_topk_detector_test;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        read_start = 1'b0;
  logic [5:0]  spike_in = '0;
  logic [15:0] tmo_limit = 16'd200;
  logic [5:0]  topk_mask;
  logic        done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spike_topk_detector uut (
    .clk(clk), .rst_n(rst_n), .read_start(read_start), .spike_in(spike_in),
    .tmo_limit(tmo_limit), .topk_mask(topk_mask), .done(done)
  );

  // {tie case, expected mask, second-spike cycle ch5..ch0}; first spike 4 cycles earlier
  localparam logic [54:0] VEC [7] = '{
    {1'b0, 6'b000111, 8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10},
    {1'b0, 6'b111000, 8'd10, 8'd20, 8'd30, 8'd40, 8'd50, 8'd60},
    {1'b0, 6'b101010, 8'd18, 8'd33, 8'd9,  8'd40, 8'd12, 8'd25},
    {1'b1, 6'b001111, 8'd35, 8'd30, 8'd20, 8'd20, 8'd14, 8'd10},
    {1'b1, 6'b111111, 8'd15, 8'd15, 8'd15, 8'd15, 8'd15, 8'd15},
    {1'b0, 6'b000111, 8'd42, 8'd41, 8'd40, 8'd22, 8'd22, 8'd22},
    {1'b1, 6'b101111, 8'd30, 8'd50, 8'd8,  8'd30, 8'd8,  8'd30}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] lead(input logic [47:0] t2v);
    logic [47:0] r;
    for (int i = 0; i < N; i++)
      r[i*8 +: 8] = (t2v[i*8 +: 8] != 0) ? t2v[i*8 +: 8] - 8'd4 : 8'd0;
    return r;
  endfunction

  // called at a falling edge; opens a measurement and plays spikes for ncyc cycles
  task automatic run_case(input logic [47:0] t1v, input logic [47:0] t2v, input int lim,
                          input int ncyc, input int quiet_at, input string qreq);
    tmo_limit = 16'(lim);
    read_start = 1'b1;
    @(negedge clk);
    read_start = 1'b0;
    for (int c = 1; c <= ncyc; c++) begin
      if (c == quiet_at) check(qreq, 32'(done), 32'd0);
      for (int i = 0; i < N; i++) begin
        int a, b;
        a = int'(t1v[i*8 +: 8]);
        b = int'(t2v[i*8 +: 8]);
        spike_in[i] = (a != 0 && (c == a || c == a + 1)) ||
                      (b != 0 && (c == b || c == b + 1));
      end
      @(negedge clk);
    end
    spike_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mask after reset", 32'(topk_mask), 32'd0);
    check("R1 done after reset", 32'(done), 32'd0);

    // table walk: all channels finish well inside the timeout
    for (int v = 0; v < 7; v++) begin
      logic [47:0] t2v;
      int last;
      t2v = VEC[v][47:0];
      last = 0;
      for (int i = 0; i < N; i++)
        if (int'(t2v[i*8 +: 8]) > last) last = int'(t2v[i*8 +: 8]);
      run_case(lead(t2v), t2v, 200, 80, last, "R6 done early");
      if (VEC[v][54]) check("R5 tied third rank", 32'(topk_mask), 32'(VEC[v][53:48]));
      else            check("R4 top three", 32'(topk_mask), 32'(VEC[v][53:48]));
      check("R6 done after last interval", 32'(done), 32'd1);
    end

    // timeout: ch0, ch1 finish; ch2 spikes once; ch3..ch5 silent
    run_case({8'd0, 8'd0, 8'd0, 8'd6, 8'd11, 8'd6},
             {8'd0, 8'd0, 8'd0, 8'd0, 8'd15, 8'd10}, 40, 60, 30, "R7 done before limit");
    check("R7 timeout mask", 32'(topk_mask), 32'h03);
    check("R3 single spike not selected", 32'(topk_mask[2]), 32'd0);
    check("R7 done at timeout", 32'(done), 32'd1);

    // spikes after done are ignored
    for (int c = 0; c < 16; c++) begin
      spike_in = (c % 4 < 2) ? 6'h3f : 6'h00;
      @(negedge clk);
    end
    spike_in = '0;
    repeat (4) @(negedge clk);
    check("R8 mask held", 32'(topk_mask), 32'h03);
    check("R8 done held", 32'(done), 32'd1);

    // start clears the result
    tmo_limit = 16'd200;
    read_start = 1'b1;
    @(negedge clk);
    read_start = 1'b0;
    check("R2 mask cleared", 32'(topk_mask), 32'd0);
    check("R2 done cleared", 32'(done), 32'd0);

    // ch5 spikes once, then a restart; stale count would end ch5 early
    for (int c = 1; c <= 12; c++) begin
      spike_in[5] = (c == 5 || c == 6);
      @(negedge clk);
    end
    spike_in = '0;
    run_case({8'd10, 8'd46, 8'd36, 8'd26, 8'd16, 8'd6},
             {8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10}, 200, 80, 60, "R6 done early");
    check("R9 restart discards counts", 32'(topk_mask), 32'h07);
    check("R9 done after restart", 32'(done), 32'd1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule